// File: doc/BRIEF.md
# Packet-Driven Control Sequencer

This block is the central control loop of a board controller that answers a host over a network interface chip. It holds a 3-bit state code, and each code names the sub-unit that owns the board at that moment: hard reset, soft reset, idle wait, header inspection, sensor query, converter programming and reply transmission. On entry to a state the sequencer fires a single start strobe to the matching sub-unit. It then waits for that sub-unit's completion pulse and moves to the state the completion implies.

The sub-units themselves sit outside this block, and each one is seen only through its start/done pair. The header inspector hands over two payload bytes, a board address and a command letter, with a valid pulse. The sequencer takes them only while it sits in the inspection state and signals this on `hdr_ready`; a valid pulse at any other time is dropped, so the inspector must hold its result until ready is high. Commands for a different board, or with an unknown letter, are dropped with a one-cycle reject pulse and send no reply. Both reply codes lead to the same transmitter, and bit 1 of the code selects whether it sends a status reply or a converter-values reply.

Top module: `pkt_seq`

## Requirements
- R1: While `rst` is high (synchronous, active high) the state code is 000, no start strobe is raised, `reject` is low and `tx_kind` is 8'h00. The cycle after `rst` falls shows the hard-reset strobe `mod_start[0]` with state 000.
- R2: `mod_start` bits are 0 hard reset, 1 soft reset, 2 idle, 3 header inspection, 4 query, 5 programming, 6 transmit. Each entry into a state raises exactly the one matching bit for exactly one cycle. No strobe is raised while the state is unchanged.
- R3: A completion from hard reset (state 000) or from soft reset (state 001) moves the sequencer to 101, so a status reply always follows a reset.
- R4: State 010 is held until `rx_irq` is sampled high. It then moves to 011. Completion pulses of other units do not move it.
- R5: In state 011 an accepted header with address equal to `BOARD_ADDR` dispatches on the command byte: 8'h51 ('Q') to 100, 8'h50 ('P') to 110, 8'h48 ('H') to 000, 8'h53 ('S') to 001.
- R6: An accepted header with a wrong address or with any other command byte returns the state to 010. `reject` then stays high for exactly the first cycle in 010, and no transmit strobe follows.
- R7: Query completion (state 100) moves to 101. Programming completion (state 110) moves to 111.
- R8: `tx_kind` is 8'h53 in state 101 and 8'h44 in state 111, and 8'h00 in all other states. Transmit completion in either code returns to 010.
- R9: Any event sampled in the cycle of a state's start strobe is ignored. Completion pulses of units other than the one owning the current state are also ignored.
- R10: `hdr_ready` is high only in state 011, from the cycle after its strobe onward. A header valid pulse outside that window has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hrst_done | input | 1 | Hard-reset unit completion pulse |
| srst_done | input | 1 | Soft-reset unit completion pulse |
| rx_irq | input | 1 | Receive buffer holds a packet |
| hdr_valid | input | 1 | Header bytes valid (inspector completion) |
| hdr_ready | output | 1 | Sequencer accepts header bytes this cycle |
| hdr_loc | input | 8 | Board address byte from the packet |
| hdr_type | input | 8 | Command letter byte from the packet |
| query_done | input | 1 | Query unit completion pulse |
| prog_done | input | 1 | Programming unit completion pulse |
| tx_done | input | 1 | Transmit unit completion pulse |
| mod_start | output | 7 | One-cycle start strobes, one bit per unit |
| state_code | output | 3 | Current state code |
| tx_kind | output | 8 | Reply letter for the transmitter, 0 outside transmit |
| reject | output | 1 | One-cycle pulse on a dropped header |

## Verification
The dispatch path is driven with each of the four valid command letters. Each must lead to its own state sequence and, where a reply follows, to the right reply letter, which shows the command decode and the reply selection are not crossed. Two bad headers, one with a neighbouring address and one with an unknown letter, separate the address check from the letter check. Both must give a reject pulse and no reply. Stray inputs are also applied: foreign completions, a header valid pulse outside inspection, and an interrupt held through a strobe cycle. Each must leave the state code unchanged, and this tells guarded transitions apart from unguarded ones.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    ST_HRST  = 3'b000,
    ST_SRST  = 3'b001,
    ST_IDLE  = 3'b010,
    ST_READ  = 3'b011,
    ST_QUERY = 3'b100,
    ST_TXS   = 3'b101,
    ST_PROG  = 3'b110,
    ST_TXD   = 3'b111
  } state_t;

  localparam int NMOD = 7;
  localparam int MODW = $clog2(NMOD);

  localparam int M_HRST  = 0;
  localparam int M_SRST  = 1;
  localparam int M_IDLE  = 2;
  localparam int M_READ  = 3;
  localparam int M_QUERY = 4;
  localparam int M_PROG  = 5;
  localparam int M_TX    = 6;

  localparam logic [7:0] ASC_STATUS = 8'h53;
  localparam logic [7:0] ASC_DACVAL = 8'h44;

  // which unit owns a state code; both reply codes share the transmitter
  function automatic logic [MODW-1:0] mod_of(state_t s);
    case (s)
      ST_HRST:  return MODW'(M_HRST);
      ST_SRST:  return MODW'(M_SRST);
      ST_IDLE:  return MODW'(M_IDLE);
      ST_READ:  return MODW'(M_READ);
      ST_QUERY: return MODW'(M_QUERY);
      ST_PROG:  return MODW'(M_PROG);
      default:  return MODW'(M_TX);
    endcase
  endfunction
endpackage

// File: rtl/seq_hdr_class.sv
module seq_hdr_class
  import seq_pkg::*;
#(
  parameter logic [7:0] BOARD_ADDR = 8'h5A,
  parameter logic [7:0] TY_QUERY   = 8'h51,
  parameter logic [7:0] TY_PROG    = 8'h50,
  parameter logic [7:0] TY_HARD    = 8'h48,
  parameter logic [7:0] TY_SOFT    = 8'h53
) (
  input  logic [7:0] loc,
  input  logic [7:0] typ,
  output logic       ok,
  output state_t     dest
);
  logic known;

  always_comb begin
    known = 1'b1;
    dest  = ST_IDLE;
    case (typ)
      TY_QUERY: dest = ST_QUERY;
      TY_PROG:  dest = ST_PROG;
      TY_HARD:  dest = ST_HRST;
      TY_SOFT:  dest = ST_SRST;
      default:  known = 1'b0;
    endcase
  end

  assign ok = known && (loc == BOARD_ADDR);
endmodule

// File: rtl/seq_next.sv
module seq_next
  import seq_pkg::*;
(
  input  state_t          cur,
  input  logic            armed,
  input  logic [NMOD-1:0] ev,
  input  logic            hdr_ok,
  input  state_t          hdr_dest,
  output state_t          nxt,
  output logic            rej
);
  always_comb begin
    nxt = cur;
    rej = 1'b0;
    if (armed) begin
      case (cur)
        ST_HRST:  if (ev[M_HRST])  nxt = ST_TXS;
        ST_SRST:  if (ev[M_SRST])  nxt = ST_TXS;
        ST_IDLE:  if (ev[M_IDLE])  nxt = ST_READ;
        ST_READ:  if (ev[M_READ]) begin
                    if (hdr_ok) nxt = hdr_dest;
                    else begin
                      nxt = ST_IDLE;
                      rej = 1'b1;
                    end
                  end
        ST_QUERY: if (ev[M_QUERY]) nxt = ST_TXS;
        ST_PROG:  if (ev[M_PROG])  nxt = ST_TXD;
        default:  if (ev[M_TX])    nxt = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seq_strobe.sv
module seq_strobe
  import seq_pkg::*;
(
  input  state_t          cur,
  input  logic            fire,
  output logic [NMOD-1:0] start
);
  logic [MODW-1:0] owner;
  assign owner = mod_of(cur);

  for (genvar i = 0; i < NMOD; i++) begin : g_bit
    assign start[i] = fire && (owner == MODW'(i));
  end
endmodule

// File: rtl/pkt_seq.sv
module pkt_seq
  import seq_pkg::*;
#(
  parameter logic [7:0] BOARD_ADDR = 8'h5A,
  parameter logic [7:0] TY_QUERY   = 8'h51,
  parameter logic [7:0] TY_PROG    = 8'h50,
  parameter logic [7:0] TY_HARD    = 8'h48,
  parameter logic [7:0] TY_SOFT    = 8'h53
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hrst_done,
  input  logic            srst_done,
  input  logic            rx_irq,
  input  logic            hdr_valid,
  output logic            hdr_ready,
  input  logic [7:0]      hdr_loc,
  input  logic [7:0]      hdr_type,
  input  logic            query_done,
  input  logic            prog_done,
  input  logic            tx_done,
  output logic [NMOD-1:0] mod_start,
  output logic [2:0]      state_code,
  output logic [7:0]      tx_kind,
  output logic            reject
);
  state_t          cur, nxt, hdr_dest;
  logic            fresh, rej, rej_q, hdr_ok;
  logic [NMOD-1:0] ev;

  // event bit index equals the index of the unit that raises it
  assign ev = {tx_done, prog_done, query_done, hdr_valid,
               rx_irq, srst_done, hrst_done};

  seq_hdr_class #(
    .BOARD_ADDR(BOARD_ADDR), .TY_QUERY(TY_QUERY), .TY_PROG(TY_PROG),
    .TY_HARD(TY_HARD), .TY_SOFT(TY_SOFT)
  ) u_class (
    .loc(hdr_loc), .typ(hdr_type), .ok(hdr_ok), .dest(hdr_dest)
  );

  seq_next u_next (
    .cur(cur), .armed(!fresh), .ev(ev), .hdr_ok(hdr_ok),
    .hdr_dest(hdr_dest), .nxt(nxt), .rej(rej)
  );

  seq_strobe u_strobe (
    .cur(cur), .fire(fresh && !rst), .start(mod_start)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur   <= ST_HRST;
      fresh <= 1'b1;
      rej_q <= 1'b0;
    end else begin
      cur   <= nxt;
      fresh <= (nxt != cur);
      rej_q <= rej;
    end
  end

  assign hdr_ready  = (cur == ST_READ) && !fresh;
  assign state_code = cur;
  assign reject     = rej_q;
  assign tx_kind    = (cur == ST_TXD) ? ASC_DACVAL :
                      (cur == ST_TXS) ? ASC_STATUS : 8'h00;
endmodule

// File: rtl/pkt_seq_chk.sv
module pkt_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [6:0] mod_start,
  input logic [2:0] state_code,
  input logic [7:0] tx_kind,
  input logic       reject,
  input logic       rx_irq,
  input logic       hdr_ready
);
  assert_onehot_start_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mod_start));

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
    (mod_start != '0) |=> (mod_start == '0));

  assert_entry_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    (state_code != $past(state_code)) |-> (mod_start != '0));

  assert_reset_exit_R3: assert property (@(posedge clk) disable iff (rst)
    (($past(state_code) == 3'b000 || $past(state_code) == 3'b001) &&
     state_code != $past(state_code)) |-> (state_code == 3'b101));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'b010 && !rx_irq) |=> (state_code == 3'b010));

  assert_reject_idle_R6: assert property (@(posedge clk) disable iff (rst)
    reject |-> (state_code == 3'b010 && $past(state_code) == 3'b011));

  assert_prog_reply_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(state_code) == 3'b110 && state_code != 3'b110) |-> (state_code == 3'b111));

  assert_dac_reply_R8: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'b111) |-> (tx_kind == 8'h44));

  assert_ready_window_R10: assert property (@(posedge clk) disable iff (rst)
    hdr_ready |-> (state_code == 3'b011 && mod_start == '0));
endmodule

bind pkt_seq pkt_seq_chk u_chk (
  .clk(clk), .rst(rst), .mod_start(mod_start), .state_code(state_code),
  .tx_kind(tx_kind), .reject(reject), .rx_irq(rx_irq), .hdr_ready(hdr_ready)
);

// File: tb/pkt_seq_test.sv
module pkt_seq_test;
  localparam logic [7:0] ADDR = 8'h5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  // bench event bits: 0 hrst,1 srst,2 irq,3 hdr_valid,4 query,5 prog,6 tx
  logic [6:0] ev  = '0;
  logic [7:0] loc = '0;
  logic [7:0] typ = '0;

  logic       hdr_ready, reject;
  logic [6:0] mod_start;
  logic [2:0] state_code;
  logic [7:0] tx_kind;

  pkt_seq #(.BOARD_ADDR(ADDR)) uut (
    .clk(clk), .rst(rst), .hrst_done(ev[0]), .srst_done(ev[1]),
    .rx_irq(ev[2]), .hdr_valid(ev[3]), .hdr_ready(hdr_ready),
    .hdr_loc(loc), .hdr_type(typ), .query_done(ev[4]),
    .prog_done(ev[5]), .tx_done(ev[6]), .mod_start(mod_start),
    .state_code(state_code), .tx_kind(tx_kind), .reject(reject)
  );

  typedef struct packed {
    logic [2:0] idx;
    logic [2:0] st;
    logic [7:0] kind;
  } exp_t;

  exp_t q[$];
  int   errs = 0;
  int   checks = 0;
  bit   over = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic expect_start(input int idx, input int st, input int kind);
    exp_t e;
    e.idx  = 3'(idx);
    e.st   = 3'(st);
    e.kind = 8'(kind);
    q.push_back(e);
  endtask

  // waits gap edges, then holds event k high across exactly one edge
  task automatic fire(input int k, input int gap, input logic [7:0] l, input logic [7:0] t);
    repeat (gap) @(posedge clk);
    #2;
    ev[k] = 1'b1;
    loc   = l;
    typ   = t;
    @(posedge clk);
    #2;
    ev = '0;
  endtask

  task automatic finish_up();
    over = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // monitor: every strobe is matched against the next expected entry
  exp_t me;
  int   got;
  always @(negedge clk) begin
    if (!rst && mod_start != '0) begin
      got = -1;
      for (int i = 0; i < 7; i++) if (mod_start[i]) got = i;
      if (q.size() == 0) begin
        chk(1'b0, "R2 unexpected strobe", got, -1);
      end else begin
        me = q.pop_front();
        chk($onehot(mod_start) && got == int'(me.idx), "R2 strobe unit", got, me.idx);
        chk(state_code == me.st, "R3/R5/R7 state on entry", state_code, me.st);
        if (me.idx == 3'd6)
          chk(tx_kind == me.kind, "R8 reply letter", tx_kind, me.kind);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(state_code == 3'b000, "R1 reset state", state_code, 0);
    chk(mod_start == '0, "R1 no strobe in reset", mod_start, 0);
    chk(reject == 1'b0, "R1 no reject in reset", reject, 0);
    chk(tx_kind == 8'h00, "R1 kind in reset", tx_kind, 0);
    expect_start(0, 0, 0);
    @(posedge clk);
    #2 rst = 1'b0;

    expect_start(6, 5, 8'h53);
    fire(0, 2, 8'h00, 8'h00);
    expect_start(2, 2, 0);
    fire(6, 2, 8'h00, 8'h00);
    @(negedge clk);
    chk(tx_kind == 8'h00, "R8 kind outside reply", tx_kind, 0);

    // stray inputs in idle
    fire(4, 2, 8'h00, 8'h00);
    @(negedge clk);
    chk(state_code == 3'b010, "R4 foreign completion in idle", state_code, 2);
    fire(3, 2, ADDR, 8'h51);
    @(negedge clk);
    chk(state_code == 3'b010, "R10 header outside inspection", state_code, 2);

    // query path
    expect_start(3, 3, 0);
    fire(2, 2, 8'h00, 8'h00);
    @(negedge clk);
    chk(hdr_ready == 1'b0, "R10 ready low in strobe cycle", hdr_ready, 0);
    @(negedge clk);
    chk(hdr_ready == 1'b1, "R10 ready in inspection", hdr_ready, 1);
    fire(5, 2, 8'h00, 8'h00);
    @(negedge clk);
    chk(state_code == 3'b011, "R9 foreign completion in inspection", state_code, 3);
    expect_start(4, 4, 0);
    fire(3, 2, ADDR, 8'h51);
    expect_start(6, 5, 8'h53);
    fire(4, 2, 8'h00, 8'h00);
    expect_start(2, 2, 0);
    fire(6, 2, 8'h00, 8'h00);

    // interrupt held only through the idle strobe cycle
    fire(2, 0, 8'h00, 8'h00);
    @(negedge clk);
    chk(state_code == 3'b010, "R9 event in strobe cycle ignored", state_code, 2);

    // programming path
    expect_start(3, 3, 0);
    fire(2, 2, 8'h00, 8'h00);
    expect_start(5, 6, 0);
    fire(3, 2, ADDR, 8'h50);
    expect_start(6, 7, 8'h44);
    fire(5, 2, 8'h00, 8'h00);
    expect_start(2, 2, 0);
    fire(6, 2, 8'h00, 8'h00);

    // wrong address
    expect_start(3, 3, 0);
    fire(2, 2, 8'h00, 8'h00);
    expect_start(2, 2, 0);
    fire(3, 2, ADDR ^ 8'h01, 8'h51);
    @(negedge clk);
    chk(reject == 1'b1, "R6 reject on address", reject, 1);
    chk(state_code == 3'b010, "R6 back to idle", state_code, 2);
    @(negedge clk);
    chk(reject == 1'b0, "R6 reject one cycle", reject, 0);

    // unknown letter
    expect_start(3, 3, 0);
    fire(2, 2, 8'h00, 8'h00);
    expect_start(2, 2, 0);
    fire(3, 2, ADDR, 8'h58);
    @(negedge clk);
    chk(reject == 1'b1, "R6 reject on letter", reject, 1);
    @(negedge clk);
    chk(reject == 1'b0, "R6 reject one cycle", reject, 0);

    // hard reset command
    expect_start(3, 3, 0);
    fire(2, 2, 8'h00, 8'h00);
    expect_start(0, 0, 0);
    fire(3, 2, ADDR, 8'h48);
    expect_start(6, 5, 8'h53);
    fire(0, 2, 8'h00, 8'h00);
    expect_start(2, 2, 0);
    fire(6, 2, 8'h00, 8'h00);

    // soft reset command
    expect_start(3, 3, 0);
    fire(2, 2, 8'h00, 8'h00);
    expect_start(1, 1, 0);
    fire(3, 2, ADDR, 8'h53);
    expect_start(6, 5, 8'h53);
    fire(1, 2, 8'h00, 8'h00);
    expect_start(2, 2, 0);
    fire(6, 2, 8'h00, 8'h00);

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R2 all expected strobes seen", q.size(), 0);
    finish_up();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!over) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_up();
    end
  end
endmodule